// File: doc/BRIEF.md
# Memory Power-Up Handshake Sequencer

This block brings an on-chip memory array out of its powered-down state. After a start pulse it raises four power requests one after another: array power-on, array power-ok, periphery power-on and periphery power-ok. Each request is raised only after the memory has acknowledged the one before it. Once all four are acknowledged, the block checks that the whole status word reads exactly "all four good, nothing else". It repeats this check a bounded number of times, with a fixed wait between tries. The memory isolation control is released only when the check passes.

The requests and the isolation control leave the block as one control word. The bit positions are fixed because the power controller next to the block decodes them. A one-cycle done pulse marks the end of every run, and a fail flag tells a failed run apart from a good one. The wait between tries comes from a prescaler whose length is a parameter (one millisecond at 250 MHz by default). The per-step acknowledge waits have no limit by default. An optional cycle-count watchdog can end a stuck step as a failure.

Top module: `mem_pwrup_seq`

## Requirements
- R1: While reset is held and after it is released, the control word has only bit 15 (isolation) set, and done, fail and busy are 0.
- R2: A start pulse accepted while idle sets control bit 13 alone. The next request is raised only after the acknowledge of the current step reads 1, in this fixed order: bit 13 (acknowledged on status bit 2), bit 14 (status bit 3), bit 11 (status bit 0), bit 12 (status bit 1).
- R3: A raised request bit stays set until the next accepted start. That start clears all four request bits, sets isolation and raises bit 13 again.
- R4: After the fourth acknowledge, the check passes only when the entire STAT_W-bit status word equals 0x0F: bits 0 to 3 set and every higher bit clear.
- R5: The check is made at most RETRIES times. Consecutive tries are WAIT_CYCLES clock cycles apart. A pass on any try ends the run as a success.
- R6: On a pass, control bit 15 is cleared, fail is 0 and done pulses.
- R7: When every try fails, control bit 15 stays set, fail is 1 and done pulses. Fail then holds until the next accepted start.
- R8: Done is high for exactly one cycle per run.
- R9: A start pulse while busy has no effect on the control word or on the run in progress.
- R10: With ACK_TIMEOUT > 0, a step whose acknowledge stays low for ACK_TIMEOUT cycles ends the run: fail is 1, done pulses and isolation stays set. With ACK_TIMEOUT = 0 a step waits forever.
- R11: Busy is high from the cycle after an accepted start and falls in the cycle where done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| status_i | input | STAT_W | Acknowledge status word from the memory |
| ctrl_o | output | CTRL_W | Control word: requests at bits 11 to 14, isolation at bit 15 |
| done_o | output | 1 | One-cycle end-of-run pulse |
| fail_o | output | 1 | Last run failed |
| busy_o | output | 1 | Run in progress |

## Verification
If the step pointer were wrong, a request bit would appear out of order or ahead of its acknowledge. This is visible in the control word in the same cycle the bad transition happens. If the retry or prescaler state were wrong, the done pulse would arrive early or late compared with the count of tries times the wait length. A wrong check decision would show either as isolation released while the status word was not exactly 0x0F, or as isolation kept on a clean status. Either shows in the cycle done pulses. A wrong busy or watchdog state shows up as a start that is not ignored, or as a stuck step that never ends.

// File: rtl/mpwr_pkg.sv
package mpwr_pkg;

  localparam int ISO_BIT = 15;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_STEP  = 2'd1,
    ST_CHECK = 2'd2,
    ST_WAIT  = 2'd3
  } seq_state_t;

  // control word position of the request raised at a given step
  function automatic int req_pos(input int step);
    case (step)
      0:       return 13;
      1:       return 14;
      2:       return 11;
      default: return 12;
    endcase
  endfunction

  // status word position acknowledging a given step
  function automatic int ack_pos(input int step);
    case (step)
      0:       return 2;
      1:       return 3;
      2:       return 0;
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/mpwr_prescaler.sv
module mpwr_prescaler #(
  parameter int WAIT_CYCLES = 250000
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = $clog2(WAIT_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(WAIT_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en_i || tick_o) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/mpwr_ack_watchdog.sv
module mpwr_ack_watchdog #(
  parameter int ACK_TIMEOUT = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic clr_i,
  output logic expire_o
);
  generate
    if (ACK_TIMEOUT == 0) begin : g_off
      logic unused_wd;
      assign unused_wd = ^{clk, rst, en_i, clr_i};
      assign expire_o = 1'b0;
    end else begin : g_on
      localparam int TW = $clog2(ACK_TIMEOUT + 1);
      localparam logic [TW-1:0] LIMIT = TW'(ACK_TIMEOUT - 1);
      logic [TW-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (rst || !en_i || clr_i) cnt_q <= '0;
        else if (cnt_q != LIMIT)   cnt_q <= cnt_q + 1'b1;
      end
      assign expire_o = en_i && !clr_i && (cnt_q == LIMIT);
    end
  endgenerate
endmodule

// File: rtl/mpwr_ctrl_pack.sv
module mpwr_ctrl_pack #(
  parameter int CTRL_W = 32
) (
  input  logic [3:0]        req_i,
  input  logic              iso_i,
  output logic [CTRL_W-1:0] word_o
);
  import mpwr_pkg::*;

  always_comb begin
    word_o = '0;
    word_o[ISO_BIT] = iso_i;
    for (int k = 0; k < 4; k++) word_o[req_pos(k)] = req_i[k];
  end
endmodule

// File: rtl/mem_pwrup_seq.sv
module mem_pwrup_seq #(
  parameter int CTRL_W      = 32,
  parameter int STAT_W      = 8,
  parameter int WAIT_CYCLES = 250000,
  parameter int RETRIES     = 10,
  parameter int ACK_TIMEOUT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [STAT_W-1:0] status_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              done_o,
  output logic              fail_o,
  output logic              busy_o
);
  import mpwr_pkg::*;

  localparam int RW = $clog2(RETRIES + 1);
  localparam logic [RW-1:0] LAST_TRY = RW'(RETRIES - 1);
  localparam logic [STAT_W-1:0] ALL_GOOD = STAT_W'(15);

  seq_state_t state_q;
  logic [1:0]    step_q;
  logic [3:0]    req_q;
  logic          iso_q;
  logic [RW-1:0] tries_q;
  logic          tick, expire, ack_hit, advance;

  always_comb begin
    ack_hit = 1'b0;
    for (int k = 0; k < 4; k++)
      if (step_q == 2'(k)) ack_hit = status_i[ack_pos(k)];
  end

  assign advance = (state_q == ST_STEP) && ack_hit;

  mpwr_prescaler #(.WAIT_CYCLES(WAIT_CYCLES)) u_presc (
    .clk(clk), .rst(rst), .en_i(state_q == ST_WAIT), .tick_o(tick)
  );

  mpwr_ack_watchdog #(.ACK_TIMEOUT(ACK_TIMEOUT)) u_wdog (
    .clk(clk), .rst(rst), .en_i(state_q == ST_STEP), .clr_i(advance),
    .expire_o(expire)
  );

  mpwr_ctrl_pack #(.CTRL_W(CTRL_W)) u_pack (
    .req_i(req_q), .iso_i(iso_q), .word_o(ctrl_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      req_q   <= '0;
      iso_q   <= 1'b1;
      tries_q <= '0;
      done_o  <= 1'b0;
      fail_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            req_q   <= 4'b0001;
            step_q  <= '0;
            iso_q   <= 1'b1;
            fail_o  <= 1'b0;
            state_q <= ST_STEP;
          end
        end
        ST_STEP: begin
          if (advance) begin
            if (step_q == 2'd3) begin
              tries_q <= '0;
              state_q <= ST_CHECK;
            end else begin
              step_q <= step_q + 2'd1;
              req_q[step_q + 2'd1] <= 1'b1;
            end
          end else if (expire) begin
            fail_o  <= 1'b1;
            done_o  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_CHECK: begin
          if (status_i == ALL_GOOD) begin
            iso_q   <= 1'b0;
            done_o  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (tries_q == LAST_TRY) begin
            fail_o  <= 1'b1;
            done_o  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            tries_q <= tries_q + 1'b1;
            state_q <= ST_WAIT;
          end
        end
        default: begin
          if (tick) state_q <= ST_CHECK;
        end
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/mpwr_seq_checker.sv
module mpwr_seq_checker #(
  parameter int CTRL_W = 32,
  parameter int STAT_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic [STAT_W-1:0] status_i,
  input logic [CTRL_W-1:0] ctrl_o,
  input logic              done_o,
  input logic              fail_o,
  input logic              busy_o
);
  localparam logic [CTRL_W-1:0] REQ_BITS = CTRL_W'(32'h0000_7800);
  localparam logic [STAT_W-1:0] ALL_GOOD = STAT_W'(15);

  logic unused_chk;
  assign unused_chk = start_i;

  assert_order_b14_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(ctrl_o[14]) |-> $past(ctrl_o[13] && status_i[2]));
  assert_order_b11_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(ctrl_o[11]) |-> $past(ctrl_o[14] && status_i[3]));
  assert_order_b12_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(ctrl_o[12]) |-> $past(ctrl_o[11] && status_i[0]));
  assert_req_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> ((REQ_BITS & $past(ctrl_o) & ~ctrl_o) == '0));
  assert_iso_release_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(ctrl_o[15]) |-> (($past(status_i) == ALL_GOOD) && done_o && !fail_o));
  assert_fail_keeps_iso_R7: assert property (@(posedge clk) disable iff (rst)
    fail_o |-> ctrl_o[15]);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  assert_done_ends_busy_R11: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && $past(busy_o)));
endmodule

bind mem_pwrup_seq mpwr_seq_checker #(.CTRL_W(CTRL_W), .STAT_W(STAT_W)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .status_i(status_i),
  .ctrl_o(ctrl_o), .done_o(done_o), .fail_o(fail_o), .busy_o(busy_o)
);

// File: tb/mem_pwrup_seq_bench.sv
`timescale 1ns/1ps
module mem_pwrup_seq_bench;
  localparam int CTRL_W = 32, STAT_W = 8, WAITC = 20, TRIES = 10, TMO = 400;
  localparam logic [31:0] ISO = 32'h8000;
  localparam logic [31:0] ALLREQ = 32'h7800;

  logic clk = 0, rst = 1, start_i = 0;
  logic [STAT_W-1:0] status_i;
  logic [CTRL_W-1:0] ctrl_o;
  logic done_o, fail_o, busy_o;
  logic [3:0] stuck = 4'h0;
  logic [STAT_W-1:0] extra = '0;
  logic [3:0] d1, d2, d3;
  int checks = 0, fails = 0, cyc = 0;

  always #2 clk = ~clk;

  mem_pwrup_seq #(.CTRL_W(CTRL_W), .STAT_W(STAT_W), .WAIT_CYCLES(WAITC),
                  .RETRIES(TRIES), .ACK_TIMEOUT(TMO)) u_mem_pwrup_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .status_i(status_i),
    .ctrl_o(ctrl_o), .done_o(done_o), .fail_o(fail_o), .busy_o(busy_o));

  // memory model: acknowledges follow requests after three cycles
  always_ff @(posedge clk) begin
    d1 <= {ctrl_o[14], ctrl_o[13], ctrl_o[12], ctrl_o[11]};
    d2 <= d1;
    d3 <= d2;
  end
  assign status_i = STAT_W'(d3 & ~stuck) | extra;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected < 100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start_i = 1;
    @(negedge clk); start_i = 0;
  endtask

  task automatic wait_done(input int maxc, output int n);
    n = 0;
    while (!done_o && n < maxc) begin @(negedge clk); n++; end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 ctrl in reset", ctrl_o, ISO);
    rst = 0;
    @(negedge clk);
    check("R1 ctrl after reset", ctrl_o, ISO);
    check("R1 flags", {29'b0, done_o, fail_o, busy_o}, 0);
  endtask

  task automatic t_pass();
    int order[4];
    int k = 0, n = 0;
    logic [31:0] prev;
    pulse_start();
    check("R2 first request alone", ctrl_o, ISO | 32'h2000);
    check("R11 busy after start", busy_o, 1);
    prev = ctrl_o;
    while (!done_o && n < 500) begin
      for (int b = 11; b <= 14; b++)
        if (ctrl_o[b] && !prev[b] && k < 4) begin order[k] = b; k++; end
      prev = ctrl_o;
      @(negedge clk); n++;
    end
    check("R2 order step2", order[0], 14);
    check("R2 order step3", order[1], 11);
    check("R2 order step4", order[2], 12);
    check("R6 done seen", done_o, 1);
    check("R6 iso released", ctrl_o, ALLREQ);
    check("R6 fail low", fail_o, 0);
    check("R11 busy low at done", busy_o, 0);
    @(negedge clk);
    check("R8 done one cycle", done_o, 0);
    check("R3 requests held after run", ctrl_o, ALLREQ);
  endtask

  task automatic t_retry_fail();
    int n;
    extra = 8'h10;
    pulse_start();
    check("R3 restart clears requests", ctrl_o, ISO | 32'h2000);
    wait_done(1000, n);
    check("R4 extra bit fails check", fail_o, 1);
    check("R7 iso kept", ctrl_o, ISO | ALLREQ);
    checks++;
    if (n < (TRIES-1)*WAITC + TRIES || n > (TRIES-1)*WAITC + TRIES + 40) begin
      fails++;
      $display("FAIL R5: actual %0d cycles expected about %0d", n, (TRIES-1)*WAITC + TRIES + 20);
    end
    @(negedge clk);
    check("R8 done one cycle after fail", done_o, 0);
    check("R7 fail holds", fail_o, 1);
    extra = '0;
  endtask

  task automatic t_late_recover();
    int n;
    extra = 8'h40;
    pulse_start();
    check("R7 fail cleared by start", fail_o, 0);
    repeat (20 + 3*WAITC) @(negedge clk);
    check("R5 still busy during tries", busy_o, 1);
    extra = '0;
    wait_done(200, n);
    check("R5 later try passes", {fail_o, ctrl_o[15]}, 0);
  endtask

  task automatic t_stuck_watchdog();
    int n;
    stuck = 4'b1000;
    pulse_start();
    repeat (60) @(negedge clk);
    check("R2 held at step without ack", ctrl_o, ISO | 32'h6000);
    pulse_start();
    repeat (5) @(negedge clk);
    check("R9 start while busy ignored", ctrl_o, ISO | 32'h6000);
    check("R9 still busy", busy_o, 1);
    wait_done(1000, n);
    check("R10 timeout fails", {done_o, fail_o, ctrl_o[15]}, 3'b111);
    checks++;
    if (n + 67 < TMO) begin
      fails++;
      $display("FAIL R10: actual %0d cycles expected >= %0d", n + 67, TMO);
    end
    stuck = 4'h0;
    @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_pass();
    t_retry_fail();
    t_late_recover();
    t_stuck_watchdog();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule